// File: doc/BRIEF.md
# Monochrome Graphics RAM Refresh Scanner

This block copies a 128x64 one-bit-per-pixel image from a local frame store to a graphics LCD controller over a serial link. A single start pulse walks every scanline from the top row to the bottom row. Each row goes out as two frames. The first is an address frame with two bytes, naming the panel position. The second is a data frame with sixteen bytes of pixels. The scanner does not build the serial wire format itself. It hands bytes, one at a time, to a separate frame encoder through a valid/ready handshake. After the last byte of a frame it waits for the encoder to report the frame complete. It then holds a fixed settling pause before starting the next frame.

The panel's controller treats the image as two stacked halves of 32 lines each. A row in the lower half is addressed as the same line number in the upper half, with its horizontal position moved past the upper half's columns. Pixel bytes sit in the frame store row-major, sixteen per row, at byte address `row*16 + column`. Each byte leaves with its bit order reversed. The frame store's read port returns data one cycle after the address is presented. The next pixel byte is fetched in the same cycle that the current one is accepted.

Top module: `lcd_refresh_scanner`

## Requirements
- R1: `busy` is high in the cycle after `start` is seen while idle. It stays high until the pause after row 63's data frame has elapsed, and falls exactly `PAUSE_CYC + 1` cycles after the final `tx_done` is driven. While idle, `tx_valid` and `rd_en` stay low.
- R2: Rows are sent in order 0 to 63. Each row is an address frame of 2 bytes with `tx_is_data` = 0, followed by a data frame of 16 bytes with `tx_is_data` = 1. One refresh sends exactly 128 frames.
- R3: For rows 0 to 31, the address frame's first byte is 0x80 | row and its second byte is 0x80.
- R4: For rows 32 to 63, the address frame's first byte is 0x80 | (row - 32) and its second byte is 0x88.
- R5: Byte k of row r's data frame equals the frame store byte at address r*16 + k with bit i moved to bit 7-i. The store's data is consumed one cycle after `rd_en`.
- R6: `tx_last` is high with the final byte of every frame and low with every other byte.
- R7: After `tx_done` completes a frame, the next frame is held back by `PAUSE_CYC` = (CLK_HZ / 1,000,000) * PAUSE_US cycles. The next address byte is offered `PAUSE_CYC + 1` cycles after `tx_done`, and the next data byte `PAUSE_CYC + 2` cycles after.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_byte`, `tx_is_data` and `tx_last` hold their values into the next cycle.
- R9: A `start` pulse while `busy` is high has no effect: the refresh in progress continues from its current row and still sends exactly 128 frames.
- R10: During and right after reset, `busy`, `tx_valid` and `rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on the clock |
| start | input | 1 | Pulse to begin a full-screen refresh |
| busy | output | 1 | High while a refresh is in progress |
| rd_en | output | 1 | Frame store read strobe |
| rd_addr | output | 10 | Frame store byte address, row*16 + column |
| rd_data | input | 8 | Frame store read data, one cycle after `rd_en` |
| tx_valid | output | 1 | A byte is offered to the frame encoder |
| tx_ready | input | 1 | Frame encoder accepts the offered byte |
| tx_byte | output | 8 | Byte offered to the encoder |
| tx_is_data | output | 1 | 1 for a pixel data frame, 0 for an address frame |
| tx_last | output | 1 | Offered byte is the last of its frame |
| tx_done | input | 1 | Encoder pulse: the current frame has left the wire |

## Verification
The hardest situation to create is the encoder stalling exactly when a freshly fetched pixel byte is being loaded. Equally hard is a restart request landing mid-refresh. The bench drives `tx_ready` with three different acceptance patterns across full refreshes, so stalls fall on every byte position of both frame kinds. It also lets `tx_done` arrive after a delay that varies from frame to frame. A second refresh reloads the frame store with a different pattern and pulses `start` several times while busy. The stream check then confirms that no row restarted.

// File: rtl/lcd_refresh_scanner.sv
module lcd_refresh_scanner #(
  parameter int CLK_HZ    = 100_000_000,
  parameter int PAUSE_US  = 72,
  parameter int ROWS      = 64,
  parameter int ROW_BYTES = 16
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        start,
  output logic                                        busy,
  output logic                                        rd_en,
  output logic [$clog2(ROWS)+$clog2(ROW_BYTES)-1:0]   rd_addr,
  input  logic [7:0]                                  rd_data,
  output logic                                        tx_valid,
  input  logic                                        tx_ready,
  output logic [7:0]                                  tx_byte,
  output logic                                        tx_is_data,
  output logic                                        tx_last,
  input  logic                                        tx_done
);
  localparam int ROW_W     = $clog2(ROWS);
  localparam int COL_W     = $clog2(ROW_BYTES);
  localparam int HALF      = ROWS / 2;
  localparam int PAUSE_CYC = (CLK_HZ / 1_000_000) * PAUSE_US;
  localparam int CNT_W     = $clog2(PAUSE_CYC + 1);
  localparam logic [7:0] H_TOP = 8'h80;
  localparam logic [7:0] H_BOT = 8'h80 | 8'(ROW_BYTES / 2);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT, S_GAP} st_t;

  st_t              st;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic             is_data, out_vld, rd_pend;
  logic [7:0]       out_byte, rev;
  logic [CNT_W-1:0] gap;

  function automatic logic [7:0] vaddr(input logic [ROW_W-1:0] r);
    logic [ROW_W-1:0] line;
    line = (r >= ROW_W'(HALF)) ? r - ROW_W'(HALF) : r;
    return 8'h80 | 8'(line);
  endfunction

  for (genvar i = 0; i < 8; i++) begin : g_rev
    assign rev[i] = rd_data[7-i];
  end

  wire fire     = out_vld & tx_ready;
  wire col_end  = (col == (is_data ? COL_W'(ROW_BYTES - 1) : COL_W'(1)));
  wire gap_end  = (st == S_GAP) && (gap == '0);
  wire last_row = (row == ROW_W'(ROWS - 1));
  wire bottom   = (row >= ROW_W'(HALF));

  assign busy       = (st != S_IDLE);
  assign tx_valid   = out_vld;
  assign tx_byte    = out_byte;
  assign tx_is_data = is_data;
  assign tx_last    = out_vld & col_end;
  assign rd_en      = (gap_end && !is_data) || (st == S_SEND && is_data && fire && !col_end);
  assign rd_addr    = {row, (gap_end ? {COL_W{1'b0}} : col + COL_W'(1))};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; row <= '0; col <= '0; is_data <= 1'b0;
      out_vld <= 1'b0; rd_pend <= 1'b0; out_byte <= '0; gap <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          row <= '0; col <= '0; is_data <= 1'b0;
          out_byte <= vaddr('0); out_vld <= 1'b1; st <= S_SEND;
        end
        S_SEND: begin
          if (rd_pend) begin
            out_byte <= rev; out_vld <= 1'b1; rd_pend <= 1'b0;
          end
          if (fire) begin
            if (col_end) begin
              out_vld <= 1'b0; st <= S_WAIT;
            end else begin
              col <= col + COL_W'(1);
              if (is_data) begin
                out_vld <= 1'b0; rd_pend <= 1'b1;
              end else begin
                out_byte <= bottom ? H_BOT : H_TOP;
              end
            end
          end
        end
        S_WAIT: if (tx_done) begin
          gap <= CNT_W'(PAUSE_CYC - 1); st <= S_GAP;
        end
        S_GAP: begin
          if (gap != '0) gap <= gap - CNT_W'(1);
          else if (!is_data) begin
            is_data <= 1'b1; col <= '0; rd_pend <= 1'b1; st <= S_SEND;
          end else if (last_row) st <= S_IDLE;
          else begin
            row <= row + ROW_W'(1); is_data <= 1'b0; col <= '0;
            out_byte <= vaddr(row + ROW_W'(1)); out_vld <= 1'b1; st <= S_SEND;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte) && $stable(tx_is_data) && $stable(tx_last)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_valid && !rd_en); // R1
  AST_ADDR_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_is_data |-> tx_byte[7]); // R3
  AST_READ_BEFORE_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !tx_valid); // R5
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    start && (st == S_SEND || st == S_WAIT) |=> $stable(row)); // R9
endmodule

// File: tb/lcd_refresh_scanner_bench.sv
module lcd_refresh_scanner_bench;
  localparam int P = 72;

  logic       clk = 0, rst_n = 0, start = 0, tx_ready = 0, tx_done = 0;
  logic [7:0] rd_data = '0;
  logic       busy, rd_en, tx_valid, tx_is_data, tx_last;
  logic [9:0] rd_addr;
  logic [7:0] tx_byte;

  lcd_refresh_scanner #(.CLK_HZ(1_000_000), .PAUSE_US(72)) u_lcd_refresh_scanner (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_byte(tx_byte), .tx_is_data(tx_is_data), .tx_last(tx_last), .tx_done(tx_done));

  always #5 clk = ~clk;

  logic [7:0] mem [0:1023];
  int  checks = 0, fails = 0, cyc = 0, ready_mode = 0;
  int  frames = 0, exp_row = 0, exp_col = 0, done_wait = 0, since_done = 0;
  bit  exp_data = 0, meas = 0, stall_pend = 0, mon_on = 0;
  logic [7:0] stall_byte;

  initial forever begin
    @(posedge clk);
    if (rd_en) rd_data <= mem[rd_addr];
  end

  function automatic logic [7:0] rev8(input logic [7:0] b);
    for (int i = 0; i < 8; i++) rev8[i] = b[7-i];
  endfunction

  function automatic logic [7:0] exp_byte(input int r, input int c, input bit d);
    if (d) return rev8(mem[r*16 + c]);
    if (r < 32) return (c == 0) ? 8'(8'h80 | r) : 8'h80;
    return (c == 0) ? 8'(8'h80 | (r - 32)) : 8'h88;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    cyc++;
    tx_done = 0;
    if (mon_on) begin
      if (done_wait > 0) begin
        done_wait--;
        if (done_wait == 0) begin tx_done = 1; since_done = 0; meas = 1; end
      end else if (meas) since_done++;
      if (meas && !busy) begin
        chk(since_done == P + 1, "R1 busy fall", since_done, P + 1);
        meas = 0;
      end
      if (meas && tx_valid) begin
        chk(since_done == (exp_data ? P + 2 : P + 1), "R7 pause", since_done,
            exp_data ? P + 2 : P + 1);
        meas = 0;
      end
      if (stall_pend) begin
        chk(tx_valid && tx_byte == stall_byte, "R8 hold", tx_byte, stall_byte);
        stall_pend = 0;
      end
    end
    case (ready_mode)
      0: tx_ready = 1;
      1: tx_ready = (cyc % 3 == 0);
      default: tx_ready = ((cyc * 7) % 5) < 2;
    endcase
    if (mon_on && tx_valid && tx_ready) begin
      if (exp_row >= 64) chk(0, "R2 extra frame", exp_row, 63);
      else begin
        chk(tx_byte == exp_byte(exp_row, exp_col, exp_data),
            exp_data ? "R5 data" : (exp_row < 32 ? "R3 addr" : "R4 addr"),
            tx_byte, exp_byte(exp_row, exp_col, exp_data));
        chk(tx_is_data == exp_data, "R2 kind", tx_is_data, exp_data);
        chk(tx_last == (exp_col == (exp_data ? 15 : 1)), "R6 last", tx_last,
            exp_col == (exp_data ? 15 : 1));
        exp_col++;
        if (exp_col == (exp_data ? 16 : 2)) begin
          exp_col = 0; frames++;
          done_wait = 1 + frames % 4;
          if (!exp_data) exp_data = 1;
          else begin exp_data = 0; exp_row++; end
        end
      end
    end else if (mon_on && tx_valid) begin
      stall_pend = 1; stall_byte = tx_byte;
    end
  end

  task automatic do_reset();
    rst_n = 0;
    repeat (4) @(negedge clk);
    chk(!busy && !tx_valid && !rd_en, "R10 reset", {busy, tx_valid, rd_en}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !tx_valid && !rd_en, "R10 after reset", {busy, tx_valid, rd_en}, 0);
  endtask

  task automatic run_refresh(input int mode, input bit poke);
    ready_mode = mode; frames = 0; exp_row = 0; exp_col = 0; exp_data = 0;
    meas = 0; done_wait = 0; mon_on = 1;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy, "R1 busy rise", busy, 1);
    if (poke) begin
      repeat (700) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
      repeat (1500) @(negedge clk);
      start = 1; repeat (3) @(negedge clk); start = 0;
    end
    while (busy) @(negedge clk);
    chk(frames == 128, "R2 frame count", frames, 128);
    chk(exp_row == 64, "R9 rows completed", exp_row, 64);
    repeat (20) @(negedge clk);
    chk(!busy && !tx_valid && frames == 128, "R1 stays idle", {busy, tx_valid}, 0);
    mon_on = 0;
  endtask

  task automatic test_plain();
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 29 + 7) ^ 8'(i >> 4);
    run_refresh(0, 0);
  endtask

  task automatic test_restart_ignored();
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 113) ^ 8'hA5;
    run_refresh(1, 1);
  endtask

  task automatic test_irregular_ready();
    for (int i = 0; i < 1024; i++) mem[i] = (i % 3 == 0) ? 8'h01 : 8'(i ^ (i >> 2));
    run_refresh(2, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=busy expected=idle");
    summary();
    $finish;
  end

  initial begin
    do_reset();
    test_plain();
    test_restart_ignored();
    test_irregular_ready();
    summary();
    $finish;
  end
endmodule